// File: doc/BRIEF.md
# Period to Divisor Pair Search

This block converts a requested period, given in nanoseconds, into a pair of divisors for two cascaded counters. The product of the two divisors, multiplied by the period of the counters' base clock, should come as close as possible to the request under a selectable rounding rule. The block is sequential. A start pulse captures the request, the base period, the rounding rule, the mode and the pair that is currently pending. A one-cycle done pulse then presents the chosen divisors and the period they actually produce.

In pair mode the block first checks the pending pair. If that pair already yields the request exactly, the block returns it at once. Otherwise it runs a bounded two-level search. The search keeps the best candidate at or below the request and the best candidate at or above it, and then applies the rounding rule. In single mode the block returns one rounded and clamped divisor. All products are formed wide enough that none of them can overflow.

Top module: `divpair_search`

## Requirements
- R1: A start seen while idle captures all inputs. A base period of zero stands for BASE_DEF (100). The target tick count is the request divided by the base period, rounded down.
- R2: The search takes the outer divisor a upward from the larger of 2 and target>>DW. It continues while a <= target/a + 1 and a <= 2^DW. For each a, it takes the inner divisor b upward from the larger of 2 and target/a, and continues while a*b <= target + a + 1 and b <= 2^DW.
- R3: Every reported divisor is at most 2^DW. In pair mode a reported divisor is either zero or at least 2.
- R4: The rounding encoding is 0 = nearest, 1 = up, 2 = down, 3 = nearest. Round-up reports the candidate with the smallest achieved period that is not below the request.
- R5: Round-down reports the candidate with the largest achieved period that is not above the request.
- R6: Nearest reports the not-below candidate only when its distance to the request is strictly smaller than the distance of the not-above candidate. On a tie, or when no not-below candidate exists, nearest reports the not-above candidate.
- R7: The block skips the search and returns the pending pair when that pair, with a pending value of zero read as 2^DW, meets three conditions: both divisors exceed 1, and their product times the base equals the request. In that case the achieved period equals the request and done rises on the second clock edge after the start edge.
- R8: In single mode, div_a is the quotient of request by base, rounded by the rounding rule and clamped to 2..2^DW. div_b reads 1, and achieved is div_a times the base.
- R9: achieved always equals div_a × div_b × base. It is held on ports AW = PW+2*DW+1 bits wide, so it never overflows.
- R10: done is high for exactly one cycle per accepted start. A start that arrives while busy is ignored. All result ports hold their values between done pulses.
- R11: After reset, busy and done are low and all result ports read zero.
- R12: When the search finds no candidate in the chosen direction, both divisors and achieved read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| req_ns | input | PW | Requested period in ns |
| base_ns | input | PW | Base clock period in ns, 0 selects BASE_DEF |
| rnd | input | 2 | Rounding rule: 0/3 nearest, 1 up, 2 down |
| single | input | 1 | Single-divisor mode |
| pend_a | input | DW | Pending first divisor, 0 means 2^DW |
| pend_b | input | DW | Pending second divisor, 0 means 2^DW |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| div_a | output | DW+1 | Chosen first divisor |
| div_b | output | DW+1 | Chosen second divisor |
| achieved | output | PW+2*DW+1 | Period produced by the result |

## Verification
The bench builds the block with DW=8 and PW=16, keeping the default base of 100. With these values the 2^DW clamp becomes reachable at 256. A pending zero reads as 256, which lets the early-exit path see the top divisor. A base of 1 lets the requests cover the full target range up to 65535, where the outer bound meets the 2^DW limit. Every search in these runs finishes within a few thousand cycles. An independent behavioural model rebuilds each expected result from the bounds and rounding rules. The bench also checks the held outputs on every clock.

// File: rtl/divpair_search.sv
module divpair_search #(
  parameter int DW       = 16,
  parameter int PW       = 32,
  parameter int BASE_DEF = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PW-1:0]     req_ns,
  input  logic [PW-1:0]     base_ns,
  input  logic [1:0]        rnd,
  input  logic              single,
  input  logic [DW-1:0]     pend_a,
  input  logic [DW-1:0]     pend_b,
  output logic              busy,
  output logic              done,
  output logic [DW:0]       div_a,
  output logic [DW:0]       div_b,
  output logic [PW+2*DW:0]  achieved
);
  localparam int AW = PW + 2*DW + 1;
  localparam int MW = PW + 2*DW + 4;
  localparam int XW = DW + 2;
  localparam int CW = $clog2(PW + 2);
  localparam logic [XW-1:0] DMAX = {2'b01, {DW{1'b0}}};
  localparam logic [XW-1:0] DTOP = DMAX + XW'(1);
  localparam logic [1:0] RND_UP = 2'd1;
  localparam logic [1:0] RND_DN = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_DIV, S_USE, S_OUT, S_IN, S_FIN} st_t;
  st_t st;

  logic [PW-1:0] r_req, r_base, tgt;
  logic [1:0]    r_rnd;
  logic          r_single;
  logic [DW:0]   r_pa, r_pb;
  logic [XW-1:0] d1, d2;

  logic [PW:0]   dv_num;
  logic [PW-1:0] dv_rem, dv_den;
  logic [CW-1:0] dv_cnt;
  logic          dv_outer;

  logic [AW-1:0] glb_ns, lub_ns;
  logic [DW:0]   glb_a, glb_b, lub_a, lub_b;
  logic          glb_ok, lub_ok;

  // serial restoring divider step
  logic [PW:0] trial, rem_nx;
  logic        ge;
  assign trial  = {dv_rem, dv_num[PW]};
  assign ge     = trial >= {1'b0, dv_den};
  assign rem_nx = ge ? (trial - {1'b0, dv_den}) : trial;

  // candidate evaluation
  logic [AW-1:0] cand, pex, req_w;
  logic [MW-1:0] prod12, limit;
  logic          in_ok, exact;
  assign req_w  = AW'(r_req);
  assign cand   = AW'(r_base) * AW'(d1) * AW'(d2);
  assign prod12 = MW'(d1) * MW'(d2);
  assign limit  = MW'(tgt) + MW'(d1) + MW'(1);
  assign in_ok  = (prod12 <= limit) && (d2 <= DMAX);
  assign pex    = AW'(r_base) * AW'(r_pa) * AW'(r_pb);
  assign exact  = (pex == req_w) && (r_pa > (DW+1)'(1)) && (r_pb > (DW+1)'(1));

  // quotient consumers
  logic [MW-1:0] q_w, q_hi;
  logic          outer_ok;
  logic [XW-1:0] d1_start, d2_start;
  assign q_w      = MW'(dv_num);
  assign q_hi     = q_w >> DW;
  assign outer_ok = (MW'(d1) <= q_w + MW'(1)) && (d1 <= DMAX);
  assign d1_start = (q_hi < MW'(2)) ? XW'(2) : (q_hi > MW'(DTOP)) ? DTOP : q_hi[XW-1:0];
  assign d2_start = (q_w < MW'(2)) ? XW'(2) : (q_w > MW'(DTOP)) ? DTOP : q_w[XW-1:0];

  // single mode
  logic [PW:0]   s_num;
  logic [DW:0]   s_div;
  logic [AW-1:0] s_ns;
  assign s_num = {1'b0, r_req} + ((r_rnd == RND_UP) ? {1'b0, r_base - PW'(1)} :
                                  (r_rnd == RND_DN) ? '0 : {2'b00, r_base[PW-1:1]});
  assign s_div = (q_w < MW'(2)) ? (DW+1)'(2) :
                 (q_w > MW'(DMAX)) ? DMAX[DW:0] : q_w[DW:0];
  assign s_ns  = AW'(s_div) * AW'(r_base);

  // rounding selection
  logic [AW-1:0] low_ns;
  logic          pick_lub;
  assign low_ns   = glb_ok ? glb_ns : '0;
  assign pick_lub = (r_rnd == RND_UP) ? 1'b1 :
                    (r_rnd == RND_DN) ? 1'b0 :
                    (lub_ok && ((lub_ns - req_w) < (req_w - low_ns)));

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      done <= 1'b0;
      div_a <= '0; div_b <= '0; achieved <= '0;
      r_req <= '0; r_base <= '0; r_rnd <= '0; r_single <= 1'b0;
      r_pa <= '0; r_pb <= '0; tgt <= '0; d1 <= '0; d2 <= '0;
      dv_num <= '0; dv_rem <= '0; dv_den <= '0; dv_cnt <= '0; dv_outer <= 1'b0;
      glb_ns <= '0; lub_ns <= '0; glb_a <= '0; glb_b <= '0; lub_a <= '0; lub_b <= '0;
      glb_ok <= 1'b0; lub_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          r_req    <= req_ns;
          r_base   <= (base_ns == '0) ? PW'(BASE_DEF) : base_ns;
          r_rnd    <= rnd;
          r_single <= single;
          r_pa     <= (pend_a == '0) ? DMAX[DW:0] : {1'b0, pend_a};
          r_pb     <= (pend_b == '0) ? DMAX[DW:0] : {1'b0, pend_b};
          st       <= S_CHK;
        end
        S_CHK: begin
          glb_ok <= 1'b0; lub_ok <= 1'b0;
          glb_ns <= '0; lub_ns <= '0;
          glb_a <= '0; glb_b <= '0; lub_a <= '0; lub_b <= '0;
          dv_rem <= '0; dv_cnt <= '0; dv_outer <= 1'b0; dv_den <= r_base;
          if (!r_single && exact) begin
            div_a <= r_pa; div_b <= r_pb; achieved <= req_w;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            dv_num <= r_single ? s_num : {1'b0, r_req};
            st <= S_DIV;
          end
        end
        S_DIV: begin
          dv_rem <= rem_nx[PW-1:0];
          dv_num <= {dv_num[PW-1:0], ge};
          dv_cnt <= dv_cnt + CW'(1);
          if (dv_cnt == CW'(PW)) st <= S_USE;
        end
        S_USE: begin
          if (r_single) begin
            div_a <= s_div; div_b <= (DW+1)'(1); achieved <= s_ns;
            done <= 1'b1;
            st <= S_IDLE;
          end else if (!dv_outer) begin
            tgt <= dv_num[PW-1:0];
            d1  <= d1_start;
            st  <= S_OUT;
          end else if (outer_ok) begin
            d2 <= d2_start;
            st <= S_IN;
          end else begin
            st <= S_FIN;
          end
        end
        S_OUT: begin
          dv_num <= {1'b0, tgt};
          dv_den <= PW'(d1);
          dv_rem <= '0; dv_cnt <= '0; dv_outer <= 1'b1;
          st <= S_DIV;
        end
        S_IN: begin
          if (in_ok) begin
            if (cand <= req_w && (!glb_ok || cand > glb_ns)) begin
              glb_ok <= 1'b1; glb_ns <= cand; glb_a <= d1[DW:0]; glb_b <= d2[DW:0];
            end
            if (cand >= req_w && (!lub_ok || cand < lub_ns)) begin
              lub_ok <= 1'b1; lub_ns <= cand; lub_a <= d1[DW:0]; lub_b <= d2[DW:0];
            end
            d2 <= d2 + XW'(1);
          end else begin
            d1 <= d1 + XW'(1);
            st <= S_OUT;
          end
        end
        S_FIN: begin
          div_a    <= pick_lub ? lub_a : glb_a;
          div_b    <= pick_lub ? lub_b : glb_b;
          achieved <= pick_lub ? lub_ns : glb_ns;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/divpair_search_chk.sv
module divpair_search_chk #(
  parameter int DW = 16,
  parameter int PW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [DW:0]      div_a,
  input logic [DW:0]      div_b,
  input logic [PW+2*DW:0] achieved
);
  localparam logic [DW:0] DMAX = {1'b1, {DW{1'b0}}};

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(div_a) && $stable(div_b) && $stable(achieved)));
  // R3
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_a <= DMAX && div_b <= DMAX && div_a != (DW+1)'(1)));
  // R12
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((div_a == '0) == (achieved == '0)));
endmodule

bind divpair_search divpair_search_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .div_a(div_a), .div_b(div_b), .achieved(achieved)
);

// File: tb/test_divpair_search.sv
module test_divpair_search;
  localparam int DW = 8;
  localparam int PW = 16;
  localparam longint DMAX = 256;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, single = 1'b0;
  logic [PW-1:0] req_ns = '0, base_ns = '0;
  logic [1:0] rnd = '0;
  logic [DW-1:0] pend_a = '0, pend_b = '0;
  logic busy, done;
  logic [DW:0] div_a, div_b;
  logic [PW+2*DW:0] achieved;

  int errors = 0, checks = 0, accepted = 0, dones = 0;
  longint qa[$], qb[$], qn[$];
  string qt[$];
  longint ha = 0, hb = 0, hn = 0;

  divpair_search #(.DW(DW), .PW(PW)) i_divpair_search (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ns(req_ns), .base_ns(base_ns),
    .rnd(rnd), .single(single), .pend_a(pend_a), .pend_b(pend_b),
    .busy(busy), .done(done), .div_a(div_a), .div_b(div_b), .achieved(achieved));

  always #5 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint req, input longint base, input int rm,
                                input bit sg, input longint pa, input longint pb,
                                output longint ea, output longint eb, output longint en);
    longint b, t, st, gn, ln, ga, gb, la, lb, lo, x, q;
    bit gok, lok, up;
    b = (base == 0) ? 100 : base;
    if (sg) begin
      x = (rm == 1) ? req + b - 1 : (rm == 2) ? req : req + b / 2;
      q = x / b;
      if (q < 2) q = 2;
      if (q > DMAX) q = DMAX;
      ea = q; eb = 1; en = q * b;
      return;
    end
    pa = (pa == 0) ? DMAX : pa;
    pb = (pb == 0) ? DMAX : pb;
    if (pa > 1 && pb > 1 && pa * pb * b == req) begin
      ea = pa; eb = pb; en = req;
      return;
    end
    t = req / b;
    st = t / DMAX;
    if (st < 2) st = 2;
    gok = 0; lok = 0; gn = 0; ln = 0; ga = 0; gb = 0; la = 0; lb = 0;
    for (longint a = st; a <= t / a + 1 && a <= DMAX; a++) begin
      longint s2;
      s2 = (t / a < 2) ? 2 : t / a;
      for (longint c = s2; a * c <= t + a + 1 && c <= DMAX; c++) begin
        longint ns;
        ns = b * a * c;
        if (ns <= req && (!gok || ns > gn)) begin gok = 1; gn = ns; ga = a; gb = c; end
        if (ns >= req && (!lok || ns < ln)) begin lok = 1; ln = ns; la = a; lb = c; end
      end
    end
    lo = gok ? gn : 0;
    if (rm == 1) up = 1;
    else if (rm == 2) up = 0;
    else up = lok && ((ln - req) < (req - lo));
    if (up) begin ea = la; eb = lb; en = ln; end
    else    begin ea = ga; eb = gb; en = gn; end
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        dones++;
        if (qa.size() == 0) begin
          check("R10 unexpected done", 1, 0);
        end else begin
          string tg;
          longint ea, eb, en;
          tg = qt.pop_front(); ea = qa.pop_front(); eb = qb.pop_front(); en = qn.pop_front();
          check({tg, " div_a"}, longint'(div_a), ea);
          check({tg, " div_b"}, longint'(div_b), eb);
          check({tg, " achieved R9"}, longint'(achieved), en);
        end
        ha = longint'(div_a); hb = longint'(div_b); hn = longint'(achieved);
      end else begin
        checks++;
        if (longint'(div_a) != ha || longint'(div_b) != hb || longint'(achieved) != hn) begin
          errors++;
          $display("FAIL R10 hold: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                   div_a, div_b, achieved, ha, hb, hn);
        end
      end
    end
  end

  task automatic issue(string tag, longint req, longint base, int rm, bit sg,
                       longint pa, longint pb);
    longint ea, eb, en;
    while (busy) @(negedge clk);
    model(req, base, rm, sg, pa, pb, ea, eb, en);
    qt.push_back(tag); qa.push_back(ea); qb.push_back(eb); qn.push_back(en);
    accepted++;
    req_ns = PW'(req); base_ns = PW'(base); rnd = 2'(rm); single = sg;
    pend_a = DW'(pa); pend_b = DW'(pb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_all();
    while (busy || qa.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(string tag, longint req, longint base, int rm, bit sg,
                     longint pa, longint pb);
    issue(tag, req, base, rm, sg, pa, pb);
    finish_all();
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 busy", longint'(busy), 0);
    check("R11 done", longint'(done), 0);
    check("R11 div_a", longint'(div_a), 0);
    check("R11 achieved", longint'(achieved), 0);

    run("R1 default base", 1000, 0, 0, 0, 1, 1);
    run("R1 base 100", 1099, 100, 2, 0, 3, 3);
    run("R5 down", 1050, 100, 2, 0, 1, 1);
    run("R4 up", 1050, 100, 1, 0, 1, 1);
    run("R6 nearest below", 1050, 100, 0, 0, 1, 1);
    run("R6 nearest above", 1170, 100, 0, 0, 1, 1);
    run("R6 tie", 1100, 100, 3, 0, 1, 1);
    run("R2 full near", 65535, 1, 0, 0, 1, 1);
    run("R4 full up", 65535, 1, 1, 0, 1, 1);
    run("R5 full down", 65535, 1, 2, 0, 1, 1);
    run("R2 odd target", 60001, 1, 0, 0, 1, 1);
    run("R3 mid", 40000, 3, 1, 0, 1, 1);
    run("R12 no candidate", 150, 100, 0, 0, 1, 1);
    run("R12 up none", 150, 100, 1, 0, 1, 1);
    run("R7 not exact pend one", 512, 1, 0, 0, 1, 512 % 256);
    run("R7 exact small", 1000, 100, 1, 0, 2, 5);
    run("R8 clamp low", 50, 100, 0, 1, 1, 1);
    run("R8 clamp high", 65535, 1, 2, 1, 1, 1);
    run("R8 near", 250, 100, 0, 1, 1, 1);
    run("R8 up", 251, 100, 1, 1, 1, 1);
    run("R8 down", 299, 100, 2, 1, 1, 1);

    // R7 latency with a zero pending divisor read as 2^DW
    issue("R7 exact zero pend", 512, 1, 0, 0, 0, 2);
    check("R7 no done after one edge", longint'(done), 0);
    @(negedge clk);
    check("R7 done on second edge", longint'(done), 1);
    finish_all();

    // R10 start while busy is ignored
    issue("R10 long search", 65000, 1, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    check("R10 busy during search", longint'(busy), 1);
    req_ns = 16'd300; base_ns = 16'd100; single = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; single = 1'b0;
    finish_all();
    repeat (5) @(negedge clk);
    check("R10 done count", longint'(dones), longint'(accepted));
    check("R10 idle after", longint'(busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule